// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in memory. A request carries the virtual address, the kind of access (instruction fetch, data load or data store), the requester's privilege level, the privilege-override controls for data accesses, a bare-mode flag, the root table page number and two permission modifiers: one lets supervisor code touch user pages, the other lets loads read execute-only pages. The walker reads one table entry at a time through a single-outstanding memory port and checks the entry it ends on. It answers with either a physical address plus read, write and execute permissions, or a fault.

When a mapping is usable but its accessed flag is clear, or a store hits a page whose dirty flag is clear, the walker writes the updated entry back to the same location before it answers. Write permission is granted only for a store or for a page that is already dirty. A later first store to a clean page therefore comes back to the walker, which can then set the dirty flag. Machine-level accesses and bare mode skip the walk entirely.

Top module: `pt2_walker`

## Requirements
- R1: A request is accepted only when `req_ready` is high. `req_ready` is high only while no walk, memory access or response is in progress. `rsp_valid` and every response field stay unchanged until `rsp_ready` is seen high at a clock edge, after which `req_ready` returns the next cycle.
- R2: When the effective privilege is machine (encoding 3) or `req_bare` is set, the response has `rsp_paddr` equal to the zero-extended virtual address, all three permissions set and no fault. No memory access is made.
- R3: For loads and stores (access codes 0 fetch, 1 load, 2 store) at privilege 3 with `req_mprv` set, the effective privilege is `req_mpp`. Fetches and other levels use `req_priv` (0 user, 1 supervisor, 3 machine).
- R4: The first entry is read at root_ppn*4096 + va[31:22]*4. A pointer entry (V=1, R=W=X=0) leads to a second read at entry_ppn*4096 + va[21:12]*4. Entry bits: V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, page number bits 31:10.
- R5: An entry with V clear faults. A pointer entry found at the second level faults.
- R6: A leaf with W set and R clear (write-only or write+execute) faults.
- R7: A page with U set faults at an effective level other than user, unless the SUM input is set and the access is not a fetch. A page with U clear faults unless the effective level is supervisor.
- R8: A leaf at the first level whose page number bits 9:0 are not all zero faults.
- R9: A load needs R, or X with MXR set. A store needs W. A fetch needs X. Otherwise the walk faults.
- R10: On success, if A is clear, or the access is a store and D is clear, the entry with A set (and D set on a store) is written to the address it was read from before the response. No write happens otherwise, and none on a fault.
- R11: A second-level leaf gives paddr = {ppn, va[11:0]}. A first-level leaf gives paddr = {ppn[21:10], va[21:0]}.
- R12: The reported permissions are r = R | (X & MXR), x = X, and w = W & (store | D). A fault reports paddr 0 and no permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken on this edge |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_mprv | input | 1 | Data accesses at machine level use `req_mpp` |
| req_mpp | input | 2 | Privilege used when the override applies |
| req_bare | input | 1 | Translation off, address passes through |
| req_root_ppn | input | 22 | Page number of the first-level table |
| req_sum | input | 1 | Supervisor may load/store user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed on this edge |
| rsp_paddr | output | 34 | Physical address |
| rsp_r | output | 1 | Read permitted |
| rsp_w | output | 1 | Write permitted |
| rsp_x | output | 1 | Execute permitted |
| rsp_fault | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Memory access requested |
| mem_req_ready | input | 1 | Memory takes the access on this edge |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 34 | Byte address of the table entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry value read |

## Verification
Random cases each build a fresh one- or two-level table and mix random flags, privileges, override settings, access kinds, superpage alignment and bare mode. Across them, every leaf check is compared against a bench model that walks the same memory. Directed cases separate pairs that differ in one input only: MXR on and off for a load of an execute-only page, SUM on and off for load versus fetch, a dirty versus a clean page for the write permission, an aligned versus a misaligned superpage, and a machine-level fetch versus a load with the override set. Counting reads and writes at the memory port tells a bypass from a walk and a needed write-back from a silent one. A held response tests that the result stays stable while it waits for `rsp_ready`.

// File: rtl/pt2_pkg.sv
// Package pt2_pkg
// Shared encodings for the two-level page table walker: access kinds,
// privilege codes and bit positions inside a page table entry.
package pt2_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int B_V     = 0;
    localparam int B_R     = 1;
    localparam int B_W     = 2;
    localparam int B_X     = 3;
    localparam int B_U     = 4;
    localparam int B_A     = 6;
    localparam int B_D     = 7;
    localparam int PPN_LSB = 10;
endpackage

// File: rtl/pt2_entry_addr.sv
// Module pt2_entry_addr
// Computes the byte address of the table entry for one walk level.
// Assumes level 0 is the top table and that entries are 2**ENT_LG bytes.
module pt2_entry_addr #(
    parameter int VA_W     = 32,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 10,
    parameter int LEVELS   = 2,
    parameter int PPN_W    = 22,
    parameter int ENT_LG   = 2,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int PA_W    = PPN_W + PG_SHIFT
) (
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [LVL_W-1:0] lvl,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PA_W-1:0]  ent_addr
);
    logic [IDX_W-1:0] idx;
    int unsigned      sh;

    // Select the index field of this level and scale it by the entry size.
    always_comb begin
        sh       = PG_SHIFT + (LEVELS - 1 - int'(lvl)) * IDX_W;
        idx      = IDX_W'(vaddr >> sh);
        ent_addr = {base_ppn, {PG_SHIFT{1'b0}}} + (PA_W'(idx) << ENT_LG);
    end
endmodule

// File: rtl/pt2_leaf_eval.sv
// Module pt2_leaf_eval
// Judges one table entry read at a given level: pointer to descend through,
// fault, or usable leaf. For a leaf it forms the physical address, the
// permissions and the entry value with accessed/dirty flags updated.
// Purely combinational; assumes the entry layout of pt2_pkg.
module pt2_leaf_eval
    import pt2_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 10,
    parameter int LEVELS   = 2,
    parameter int PPN_W    = 22,
    parameter int PTE_W    = 32,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int PA_W    = PPN_W + PG_SHIFT
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [LVL_W-1:0] lvl,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [1:0]       acc,
    input  logic [1:0]       epriv,
    input  logic             sum,
    input  logic             mxr,
    output logic             go_down,
    output logic             fault,
    output logic [PA_W-1:0]  paddr,
    output logic             perm_r,
    output logic             perm_w,
    output logic             perm_x,
    output logic             need_wb,
    output logic [PTE_W-1:0] new_pte
);
    logic [PPN_W-1:0] ppn, vpn, low_mask;
    logic f_v, f_r, f_w, f_x, f_u, f_d;
    logic last, is_ptr, rsvd, usr_bad, misal, perm_bad;
    int unsigned lowb;

    // Decode the entry fields and the level-dependent superpage mask.
    always_comb begin
        ppn      = pte[PPN_LSB +: PPN_W];
        f_v      = pte[B_V];
        f_r      = pte[B_R];
        f_w      = pte[B_W];
        f_x      = pte[B_X];
        f_u      = pte[B_U];
        f_d      = pte[B_D];
        last     = (lvl == LVL_W'(LEVELS - 1));
        lowb     = (LEVELS - 1 - int'(lvl)) * IDX_W;
        low_mask = ~({PPN_W{1'b1}} << lowb);
        vpn      = PPN_W'(vaddr[VA_W-1:PG_SHIFT]);
    end

    // Apply each leaf rule and combine them into the verdict.
    always_comb begin
        is_ptr  = !f_r && !f_w && !f_x;
        rsvd    = f_w && !f_r;
        usr_bad = f_u ? ((epriv != PRIV_U) && (!sum || acc == ACC_FETCH))
                      : (epriv != PRIV_S);
        misal   = |(ppn & low_mask);
        case (acc)
            ACC_LOAD:  perm_bad = !(f_r || (f_x && mxr));
            ACC_STORE: perm_bad = !f_w;
            ACC_FETCH: perm_bad = !f_x;
            default:   perm_bad = 1'b1;
        endcase
        fault   = !f_v || (is_ptr && last) ||
                  (!is_ptr && (rsvd || usr_bad || misal || perm_bad));
        go_down = f_v && is_ptr && !last;
    end

    // Build the translated address, permissions and updated entry.
    always_comb begin
        paddr   = {(ppn & ~low_mask) | (vpn & low_mask), vaddr[PG_SHIFT-1:0]};
        perm_r  = f_r || (f_x && mxr);
        perm_x  = f_x;
        perm_w  = f_w && (acc == ACC_STORE || f_d);
        new_pte = pte | (PTE_W'(1) << B_A) |
                  ((acc == ACC_STORE) ? (PTE_W'(1) << B_D) : '0);
        need_wb = (new_pte != pte);
    end
endmodule

// File: rtl/pt2_walker.sv
// Module pt2_walker
// Two-level page table walker with a valid/ready request and response and a
// single-outstanding memory port. Reads arrive some cycles after a read is
// taken (mem_rvalid); writes complete on acceptance. Only one translation is
// in flight; the response is held until consumed.
module pt2_walker
    import pt2_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 10,
    parameter int LEVELS   = 2,
    parameter int PPN_W    = 22,
    parameter int PTE_W    = 32,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int PA_W    = PPN_W + PG_SHIFT,
    localparam int ENT_LG  = $clog2(PTE_W / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_priv,
    input  logic             req_mprv,
    input  logic [1:0]       req_mpp,
    input  logic             req_bare,
    input  logic [PPN_W-1:0] req_root_ppn,
    input  logic             req_sum,
    input  logic             req_mxr,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_r,
    output logic             rsp_w,
    output logic             rsp_x,
    output logic             rsp_fault,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WAIT, ST_WB, ST_RSP} st_e;

    st_e              state;
    logic [LVL_W-1:0] lvl;
    logic [PPN_W-1:0] base_ppn;
    logic [VA_W-1:0]  va_q;
    logic [1:0]       acc_q, epriv_q;
    logic             sum_q, mxr_q;
    logic [PTE_W-1:0] wb_q;
    logic [1:0]       eff_priv;
    logic             bypass;
    logic [PA_W-1:0]  ent_addr;

    logic             e_down, e_fault, e_r, e_w, e_x, e_wb;
    logic [PA_W-1:0]  e_paddr;
    logic [PTE_W-1:0] e_new;

    // Effective privilege and whether the walk is skipped.
    always_comb begin
        eff_priv = (req_priv == PRIV_M && req_acc != ACC_FETCH && req_mprv)
                   ? req_mpp : req_priv;
        bypass   = (eff_priv == PRIV_M) || req_bare;
    end

    pt2_entry_addr #(
        .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .PPN_W(PPN_W), .ENT_LG(ENT_LG)
    ) u_addr (
        .base_ppn(base_ppn), .lvl(lvl), .vaddr(va_q), .ent_addr(ent_addr)
    );

    pt2_leaf_eval #(
        .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .PPN_W(PPN_W), .PTE_W(PTE_W)
    ) u_eval (
        .pte(mem_rdata), .lvl(lvl), .vaddr(va_q), .acc(acc_q),
        .epriv(epriv_q), .sum(sum_q), .mxr(mxr_q),
        .go_down(e_down), .fault(e_fault), .paddr(e_paddr),
        .perm_r(e_r), .perm_w(e_w), .perm_x(e_x),
        .need_wb(e_wb), .new_pte(e_new)
    );

    // Port-side views of the state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        rsp_valid     = (state == ST_RSP);
        mem_req_valid = (state == ST_RD) || (state == ST_WB);
        mem_we        = (state == ST_WB);
        mem_addr      = ent_addr;
        mem_wdata     = wb_q;
    end

    // Walk sequencer: accept, read levels, write back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lvl       <= '0;
            base_ppn  <= '0;
            va_q      <= '0;
            acc_q     <= '0;
            epriv_q   <= '0;
            sum_q     <= 1'b0;
            mxr_q     <= 1'b0;
            wb_q      <= '0;
            rsp_paddr <= '0;
            rsp_r     <= 1'b0;
            rsp_w     <= 1'b0;
            rsp_x     <= 1'b0;
            rsp_fault <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q     <= req_vaddr;
                    acc_q    <= req_acc;
                    epriv_q  <= eff_priv;
                    sum_q    <= req_sum;
                    mxr_q    <= req_mxr;
                    base_ppn <= req_root_ppn;
                    lvl      <= '0;
                    if (bypass) begin
                        rsp_paddr <= PA_W'(req_vaddr);
                        rsp_r     <= 1'b1;
                        rsp_w     <= 1'b1;
                        rsp_x     <= 1'b1;
                        rsp_fault <= 1'b0;
                        state     <= ST_RSP;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_RD: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rvalid) begin
                    if (e_fault) begin
                        rsp_paddr <= '0;
                        rsp_r     <= 1'b0;
                        rsp_w     <= 1'b0;
                        rsp_x     <= 1'b0;
                        rsp_fault <= 1'b1;
                        state     <= ST_RSP;
                    end else if (e_down) begin
                        base_ppn <= mem_rdata[PPN_LSB +: PPN_W];
                        lvl      <= lvl + 1'b1;
                        state    <= ST_RD;
                    end else begin
                        rsp_paddr <= e_paddr;
                        rsp_r     <= e_r;
                        rsp_w     <= e_w;
                        rsp_x     <= e_x;
                        rsp_fault <= 1'b0;
                        wb_q      <= e_new;
                        state     <= e_wb ? ST_WB : ST_RSP;
                    end
                end
                ST_WB: if (mem_req_ready) state <= ST_RSP;
                ST_RSP: if (rsp_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt2_walker_chk.sv
// Module pt2_walker_chk
// Protocol and result properties of pt2_walker, observed at its ports.
// Keeps its own copy of the accepted access kind.
module pt2_walker_chk
    import pt2_pkg::*;
#(
    parameter int PA_W  = 34,
    parameter int PTE_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_acc,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_r,
    input logic             rsp_w,
    input logic             rsp_x,
    input logic             rsp_fault,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_wdata
);
    logic [1:0] acc_seen;

    // Remember the access kind of the request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_seen <= '0;
        else if (req_valid && req_ready) acc_seen <= req_acc;
    end

    // R1
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) &&
        $stable(rsp_fault) && $stable({rsp_r, rsp_w, rsp_x}));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid && !mem_req_valid);

    // R1
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
        && $stable(mem_we));

    // R12
    fault_noperm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !rsp_r && !rsp_w && !rsp_x && rsp_paddr == '0);

    // R10
    wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_we |-> mem_wdata[B_A]);

    // R10
    wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_we && acc_seen == ACC_STORE |-> mem_wdata[B_D]);

    // R9
    store_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && acc_seen == ACC_STORE |-> rsp_w);

    // R9
    fetch_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && acc_seen == ACC_FETCH |-> rsp_x);

    // R9
    load_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && acc_seen == ACC_LOAD |-> rsp_r);
endmodule

bind pt2_walker pt2_walker_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x),
    .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/tb_pt2_walker.sv
// Bench for pt2_walker: directed corners plus seeded random tables, each
// compared against a reference walk over the bench's own memory.
module tb_pt2_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0, req_priv = '0, req_mpp = '0;
    logic        req_mprv = 1'b0, req_bare = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
    logic [21:0] req_root_ppn = '0;
    logic        rsp_valid, rsp_ready = 1'b0;
    logic [33:0] rsp_paddr;
    logic        rsp_r, rsp_w, rsp_x, rsp_fault;
    logic        mem_req_valid, mem_req_ready = 1'b1, mem_we;
    logic [33:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FA = 8'h40, FD = 8'h80;

    int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;
    bit [31:0] pmem [bit [33:0]];

    always #4 clk = ~clk;

    pt2_walker dut (.*);

    // Memory model: reads return one cycle after acceptance.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_we) begin
                pmem[mem_addr] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= pmem.exists(mem_addr) ? pmem[mem_addr] : 32'h0;
                rd_cnt++;
            end
        end
    end

    // Random backpressure on the memory port.
    always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [33:0] ea(bit [21:0] ppn, bit [9:0] idx);
        return {ppn, 12'h0} + {22'h0, idx, 2'b00};
    endfunction

    function automatic bit [31:0] mk(bit [21:0] ppn, bit [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    function automatic bit [31:0] rd(bit [33:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    // Reference walk computed from the requirements.
    task automatic ref_walk(input bit [31:0] va, input bit [1:0] acc, priv,
                            input bit mprv, input bit [1:0] mpp, input bit bare,
                            input bit [21:0] root, input bit sum, mxr,
                            output bit [37:0] res, output int nrd,
                            output bit wb, output bit [33:0] wa,
                            output bit [31:0] wv);
        bit [1:0] ep; bit [21:0] base; bit [31:0] pte; bit [33:0] a;
        bit v, r, w, x, u, d, bad, done;
        ep = (priv == 2'd3 && acc != 2'd0 && mprv) ? mpp : priv;
        res = '0; nrd = 0; wb = 0; wa = '0; wv = '0; done = 0;
        if (ep == 2'd3 || bare) begin
            res = {1'b0, 3'b111, 2'b00, va};
        end else begin
            base = root;
            for (int l = 0; l < 2 && !done; l++) begin
                a = ea(base, l == 0 ? va[31:22] : va[21:12]);
                pte = rd(a); nrd++;
                v = pte[0]; r = pte[1]; w = pte[2]; x = pte[3]; u = pte[4]; d = pte[7];
                if (!v) begin res = {1'b1, 37'h0}; done = 1; end
                else if (!r && !w && !x) begin
                    if (l == 1) begin res = {1'b1, 37'h0}; done = 1; end
                    else base = pte[31:10];
                end else begin
                    bad = (w && !r);
                    bad |= u ? (ep != 2'd0 && (!sum || acc == 2'd0)) : (ep != 2'd1);
                    bad |= (l == 0) && (pte[19:10] != 0);
                    bad |= (acc == 2'd1) ? !(r || (x && mxr)) :
                           (acc == 2'd2) ? !w : !x;
                    done = 1;
                    if (bad) res = {1'b1, 37'h0};
                    else begin
                        res[37] = 1'b0;
                        res[36] = r || (x && mxr);
                        res[35] = w && (acc == 2'd2 || d);
                        res[34] = x;
                        res[33:0] = (l == 0) ? {pte[31:20], va[21:0]} : {pte[31:10], va[11:0]};
                        wv = pte | 32'h40 | ((acc == 2'd2) ? 32'h80 : 32'h0);
                        wb = (wv != pte); wa = a;
                    end
                end
            end
        end
    endtask

    // Drive one request, compare result, port traffic and write-back.
    task automatic run_case(string tag, bit [31:0] va, bit [1:0] acc, priv,
                            bit mprv, bit [1:0] mpp, bit bare, bit [21:0] root,
                            bit sum, mxr, bit hold);
        bit [37:0] exp, held; int nrd, rd0, wr0; bit wb; bit [33:0] wa; bit [31:0] wv;
        ref_walk(va, acc, priv, mprv, mpp, bare, root, sum, mxr, exp, nrd, wb, wa, wv);
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_priv = priv; req_mprv = mprv;
        req_mpp = mpp; req_bare = bare; req_root_ppn = root; req_sum = sum;
        req_mxr = mxr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        if (hold) begin
            held = {rsp_fault, rsp_r, rsp_w, rsp_x, rsp_paddr};
            repeat (3) @(negedge clk);
            check({tag, " R1 hold"}, {rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x, rsp_paddr},
                  {1'b1, held});
        end
        check({tag, " result"}, {rsp_fault, rsp_r, rsp_w, rsp_x, rsp_paddr}, exp);
        check({tag, " R4 reads"}, rd_cnt - rd0, nrd);
        check({tag, " R10 writes"}, wr_cnt - wr0, wb ? 1 : 0);
        if (wb) check({tag, " R10 wdata"}, rd(wa), wv);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check({tag, " R1 ready"}, req_ready, 1);
    endtask

    task automatic put1(bit [21:0] root, bit [31:0] va, bit [21:0] ppn, bit [7:0] fl);
        pmem.delete();
        pmem[ea(root, va[31:22])] = mk(ppn, fl);
    endtask

    task automatic put2(bit [21:0] root, bit [31:0] va, bit [21:0] mid,
                        bit [21:0] ppn, bit [7:0] fl);
        pmem.delete();
        pmem[ea(root, va[31:22])] = mk(mid, FV);
        pmem[ea(mid, va[21:12])]  = mk(ppn, fl);
    endtask

    localparam bit [31:0]  VA   = 32'h4030_5abc;
    localparam bit [21:0]  ROOT = 22'h00100, MID = 22'h00200, PG = 22'h12345;

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        check("R1 reset ready", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
        rst_n = 1'b1;

        // R2 bypass: machine level and bare mode
        put2(ROOT, VA, MID, PG, FV | FR | FA);
        run_case("R2 m-load", VA, 2'd1, 2'd3, 0, 2'd0, 0, ROOT, 0, 0, 0);
        run_case("R2 bare", VA, 2'd0, 2'd1, 0, 2'd0, 1, ROOT, 0, 0, 0);
        // R3 override for a load, not for a fetch
        put2(ROOT, VA, MID, PG, FV | FR | FX | FA);
        run_case("R3 mprv-load", VA, 2'd1, 2'd3, 1, 2'd1, 0, ROOT, 0, 0, 0);
        run_case("R3 mprv-fetch", VA, 2'd0, 2'd3, 1, 2'd1, 0, ROOT, 0, 0, 0);
        // R4 R10 R11 4K store on clean page
        put2(ROOT, VA, MID, PG, FV | FR | FW);
        run_case("R11 store", VA, 2'd2, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        // R8 misaligned superpage vs aligned
        put1(ROOT, VA, 22'h12301, FV | FR | FA);
        run_case("R8 misal", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        put1(ROOT, VA, 22'h12400, FV | FR | FA | FD);
        run_case("R11 super", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        // R6 reserved encodings
        put2(ROOT, VA, MID, PG, FV | FW | FA);
        run_case("R6 w-only", VA, 2'd2, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        put2(ROOT, VA, MID, PG, FV | FW | FX | FA);
        run_case("R6 wx", VA, 2'd0, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        // R5 invalid and pointer at last level
        put2(ROOT, VA, MID, PG, FR | FA);
        run_case("R5 invalid", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        put2(ROOT, VA, MID, PG, FV);
        run_case("R5 ptr-last", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        // R7 user/supervisor rule
        put2(ROOT, VA, MID, PG, FV | FR | FX | FU | FA);
        run_case("R7 sum-load", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 1, 0, 0);
        run_case("R7 sum-fetch", VA, 2'd0, 2'd1, 0, 2'd0, 0, ROOT, 1, 0, 0);
        run_case("R7 nosum-load", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        put2(ROOT, VA, MID, PG, FV | FR | FA);
        run_case("R7 user-on-s", VA, 2'd1, 2'd0, 0, 2'd0, 0, ROOT, 0, 0, 0);
        // R9 MXR on execute-only
        put2(ROOT, VA, MID, PG, FV | FX | FA);
        run_case("R9 mxr1", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 1, 0);
        run_case("R9 mxr0", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);
        // R12 dirty vs clean write permission, R10 no write when flags set
        put2(ROOT, VA, MID, PG, FV | FR | FW | FA | FD);
        run_case("R12 dirty", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 1);
        put2(ROOT, VA, MID, PG, FV | FR | FW | FA);
        run_case("R12 clean", VA, 2'd1, 2'd1, 0, 2'd0, 0, ROOT, 0, 0, 0);

        // Random tables
        for (int t = 0; t < 300; t++) begin
            bit [31:0] va; bit [21:0] root, mid, ppn; bit [7:0] fl;
            bit [1:0] acc, pr, mpp; int k;
            va = $urandom; root = 22'($urandom); mid = 22'($urandom);
            ppn = 22'($urandom);
            fl = 8'($urandom);
            if (($urandom % 10) != 0) fl[0] = 1'b1;
            acc = 2'($urandom % 3);
            k = $urandom % 3; pr = (k == 2) ? 2'd3 : 2'(k);
            k = $urandom % 3; mpp = (k == 2) ? 2'd3 : 2'(k);
            if (($urandom % 2) != 0) begin
                if (($urandom % 2) != 0) ppn[9:0] = '0;
                put1(root, va, ppn, fl);
            end else begin
                if (mid == root) mid = mid + 1'b1;
                put2(root, va, mid, ppn, fl);
            end
            run_case("R9 random", va, acc, pr, 1'($urandom), mpp,
                     ($urandom % 10) == 0, root, 1'($urandom), 1'($urandom),
                     ($urandom % 8) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule